// File: doc/BRIEF.md
# Priority Flow Control Pause Generator

This block decides which traffic priorities a port must ask its link partner to stop sending. It watches the fill level of up to eight ingress headroom buffers and rounds each byte count up to whole 96-byte cells. Each buffer has a pair of XOFF and XON thresholds, and its pause state follows them with hysteresis. A per-priority map assigns each switch priority to a buffer, so the pause state of a buffer spreads to every priority mapped to it. The result is gated either by a per-priority transmit policy or by a single global pause enable. The two policies are mutually exclusive, and a configuration write that sets both is refused.

Toward the frame builder, the block gives a level vector of the priorities now paused. It also gives a strobe that asks for a pause frame when a priority first becomes paused and again every refresh interval while any stays paused, a per-priority release strobe for a zero-time frame, and the configured pause time. On the receive side, incoming priority or ordinary pause indications load per-priority down-counters in 512-bit-time quanta. Each counter holds a stop bit toward the egress scheduler until it expires.

Top module: `pfc_pause_gen`

## Requirements
- R1: A buffer's occupancy in cells is the ceiling of its byte count divided by 96. The buffer enters the paused state on the clock edge at which its cell count is strictly greater than its XOFF threshold.
- R2: A paused buffer leaves the paused state only when its cell count is strictly below its XON threshold. Between the thresholds, and at equality with either of them, the state holds.
- R3: A buffer configured lossy (bit 24 of its threshold register at address 8+b, with XOFF in bits 11:0 and XON in bits 23:12) never pauses, whatever its thresholds and fill.
- R4: A map write (address 1) sets priority p's 4-bit buffer index from data bits 4p+3:4p, but only for priorities whose bit is set in the 8-bit update mask. An index at or above the buffer count never pauses the priority. After reset, priority p maps to buffer p.
- R5: The transmit priority mask (policy register address 0, bits 7:0, reset zero) lets a paused priority appear in the transmit pause vector. A zero bit keeps that priority clear.
- R6: With the global transmit enable (policy bit 16) set, all priorities are requested whenever any priority is paused. A policy write that sets bit 16 together with a nonzero transmit mask is refused: it raises the reject output in that cycle and leaves the policy unchanged.
- R7: The refresh strobe fires in the cycle in which any priority newly enters the transmit pause vector, and again every N cycles while the vector stays nonzero. N is timer register (address 2) bits 31:16, and N = 0 disables the periodic strobe. The pause time output equals bits 15:0 of that register.
- R8: A priority that leaves the transmit pause vector raises its release bit for exactly that one cycle.
- R9: A received priority pause loads each listed priority's counter with the quanta value, provided that priority's bit is set in the receive mask (policy bits 15:8). A received ordinary pause loads all counters when the global receive bit (policy bit 17) is set. Requests not enabled by the policy are ignored. A stop bit is high while its counter is nonzero, each quanta tick decrements it, and a quanta of zero releases at once.
- R10: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| cfgMask | input | 8 | Per-priority update mask for map writes |
| cfgReject | output | 1 | Current write is a refused conflicting policy |
| fillBytes | input | NUM_BUF*BYTE_W | Byte occupancy of each buffer, buffer b at bits b*BYTE_W upward |
| rxPfcValid | input | 1 | A priority pause request was received |
| rxPauseValid | input | 1 | An ordinary pause request was received |
| rxPrioVec | input | 8 | Priorities named in the received priority pause |
| rxQuanta | input | 16 | Received pause duration in quanta |
| quantaTick | input | 1 | One 512-bit-time quantum elapsed |
| txPauseVec | output | 8 | Priorities currently requested paused |
| txRefresh | output | 1 | Send a pause frame now |
| txRelease | output | 8 | Priorities released this cycle |
| txPauseTime | output | 16 | Pause time to place in generated frames |
| rxStop | output | 8 | Per-priority transmit stop from received pauses |

## Verification
The bound checker watches on every cycle that each newly set transmit bit comes with a refresh strobe, that release bits mark only priorities that were set one cycle earlier and are clear now, and that receive stop bits rise only after a received request and stay fixed when neither a tick nor a request arrives. Cell rounding, the hysteresis band, lossy exemption, masked map updates, out-of-range indices, the policy conflict and refresh spacing all depend on configuration. Only the bench scenarios show these, with a fill sweep across the band and expected pause state computed arithmetically.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int PRIO_N = 8;
  localparam int CELL_W = 12;
  localparam int IDX_W  = 4;
  localparam int CFG_W  = 32;
  localparam int TMR_W  = 16;

  localparam logic [3:0] ADDR_POLICY = 4'd0;
  localparam logic [3:0] ADDR_MAP    = 4'd1;
  localparam logic [3:0] ADDR_TIMER  = 4'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic              polWr;
    logic              mapWr;
    logic [PRIO_N-1:0] bufWr;
    logic [PRIO_N-1:0] mapMask;
    logic [CFG_W-1:0]  data;
  } cfg_stb_t;
endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
#(
  parameter int NUM_BUF = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [3:0]        cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [PRIO_N-1:0] cfgMask,
  input  logic [PRIO_N-1:0] txReq,
  output cfg_stb_t          stb,
  output logic              cfgReject,
  output logic              txRefresh,
  output logic [PRIO_N-1:0] txRelease,
  output logic [TMR_W-1:0]  txPauseTime
);
  logic [PRIO_N-1:0] bufHit;
  logic              isPolicy, conflict;
  logic [TMR_W-1:0]  refreshIv, refCnt;
  logic [PRIO_N-1:0] prevReq, newBits;
  logic              anyReq, expiry;

  for (genvar b = 0; b < PRIO_N; b++) begin : g_hit
    if (b < NUM_BUF) begin : g_on
      assign bufHit[b] = cfgWe && (cfgAddr == 4'(8 + b));
    end else begin : g_off
      assign bufHit[b] = 1'b0;
    end
  end

  always_comb begin
    isPolicy  = cfgWe && (cfgAddr == ADDR_POLICY);
    conflict  = cfgData[16] && (cfgData[7:0] != 8'd0);
    cfgReject = isPolicy && conflict;
    stb = '{polWr:   isPolicy && !conflict,
            mapWr:   cfgWe && (cfgAddr == ADDR_MAP),
            bufWr:   bufHit,
            mapMask: cfgMask,
            data:    cfgData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPauseTime <= '0;
      refreshIv   <= '0;
    end else if (cfgWe && cfgAddr == ADDR_TIMER) begin
      txPauseTime <= cfgData[TMR_W-1:0];
      refreshIv   <= cfgData[CFG_W-1:TMR_W];
    end
  end

  always_comb begin
    newBits   = txReq & ~prevReq;
    anyReq    = |txReq;
    expiry    = anyReq && (refreshIv != '0) && (refCnt == refreshIv - 1'b1);
    txRefresh = (|newBits) || expiry;
    txRelease = prevReq & ~txReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq <= '0;
      refCnt  <= '0;
    end else begin
      prevReq <= txReq;
      if ((|newBits) || !anyReq || expiry) refCnt <= '0;
      else                                 refCnt <= refCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int BYTE_W  = 18
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfg_stb_t                  stb,
  input  logic [NUM_BUF*BYTE_W-1:0] fillBytes,
  input  logic                      rxPfcValid,
  input  logic                      rxPauseValid,
  input  logic [PRIO_N-1:0]         rxPrioVec,
  input  logic [TMR_W-1:0]          rxQuanta,
  input  logic                      quantaTick,
  output logic [PRIO_N-1:0]         txReq,
  output logic [PRIO_N-1:0]         rxStop
);
  localparam int SUM_W    = BYTE_W + 1;
  localparam int CELL_MAX = (1 << CELL_W) - 1;
  localparam int PAD_N    = 1 << IDX_W;

  logic [PRIO_N-1:0] txMask, rxMask;
  logic              gTx, gRx;
  logic [IDX_W-1:0]  prioMap [PRIO_N];
  logic [NUM_BUF-1:0] bufPaused;
  logic [PAD_N-1:0]  bufPad;
  logic [PRIO_N-1:0] prioHot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txMask <= '0;
      rxMask <= '0;
      gTx    <= 1'b0;
      gRx    <= 1'b0;
    end else if (stb.polWr) begin
      txMask <= stb.data[7:0];
      rxMask <= stb.data[15:8];
      gTx    <= stb.data[16];
      gRx    <= stb.data[17];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PRIO_N; p++) begin
      if (!rstN)
        prioMap[p] <= IDX_W'(p % NUM_BUF);
      else if (stb.mapWr && stb.mapMask[p])
        prioMap[p] <= stb.data[p*IDX_W +: IDX_W];
    end
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [CELL_W-1:0] xoffTh, xonTh, cells;
    logic              lossy, pausedR;
    logic [SUM_W-1:0]  rounded;

    always_comb begin
      rounded = (SUM_W'(fillBytes[b*BYTE_W +: BYTE_W]) + SUM_W'(95)) / SUM_W'(96);
      cells   = (rounded > SUM_W'(CELL_MAX)) ? CELL_W'(CELL_MAX) : rounded[CELL_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        xoffTh <= CELL_W'(CELL_MAX);
        xonTh  <= '0;
        lossy  <= 1'b0;
      end else if (stb.bufWr[b]) begin
        xoffTh <= stb.data[CELL_W-1:0];
        xonTh  <= stb.data[2*CELL_W-1:CELL_W];
        lossy  <= stb.data[24];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || lossy)      pausedR <= 1'b0;
      else if (cells > xoffTh) pausedR <= 1'b1;
      else if (cells < xonTh)  pausedR <= 1'b0;
    end

    assign bufPaused[b] = pausedR;
  end

  assign bufPad = {{(PAD_N-NUM_BUF){1'b0}}, bufPaused};

  for (genvar p = 0; p < PRIO_N; p++) begin : g_prio
    logic [TMR_W-1:0] rxCnt;
    logic             load;

    assign prioHot[p] = bufPad[prioMap[p]];
    assign load = (rxPfcValid && rxPrioVec[p] && rxMask[p]) || (rxPauseValid && gRx);

    always_ff @(posedge clk) begin
      if (!rstN)                         rxCnt <= '0;
      else if (load)                     rxCnt <= rxQuanta;
      else if (quantaTick && rxCnt != 0) rxCnt <= rxCnt - 1'b1;
    end

    assign rxStop[p] = (rxCnt != '0);
  end

  assign txReq = gTx ? {PRIO_N{|prioHot}} : (prioHot & txMask);
endmodule

// File: rtl/pfc_pause_gen.sv
module pfc_pause_gen
  import pfc_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int BYTE_W  = 18
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [3:0]                cfgAddr,
  input  logic [31:0]               cfgData,
  input  logic [7:0]                cfgMask,
  output logic                      cfgReject,
  input  logic [NUM_BUF*BYTE_W-1:0] fillBytes,
  input  logic                      rxPfcValid,
  input  logic                      rxPauseValid,
  input  logic [7:0]                rxPrioVec,
  input  logic [15:0]               rxQuanta,
  input  logic                      quantaTick,
  output logic [7:0]                txPauseVec,
  output logic                      txRefresh,
  output logic [7:0]                txRelease,
  output logic [15:0]               txPauseTime,
  output logic [7:0]                rxStop
);
  cfg_stb_t   stb;
  logic [7:0] txReq;

  pfc_ctrl #(.NUM_BUF(NUM_BUF)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .cfgMask(cfgMask), .txReq(txReq), .stb(stb),
    .cfgReject(cfgReject), .txRefresh(txRefresh), .txRelease(txRelease),
    .txPauseTime(txPauseTime)
  );

  pfc_datapath #(.NUM_BUF(NUM_BUF), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fillBytes(fillBytes),
    .rxPfcValid(rxPfcValid), .rxPauseValid(rxPauseValid),
    .rxPrioVec(rxPrioVec), .rxQuanta(rxQuanta), .quantaTick(quantaTick),
    .txReq(txReq), .rxStop(rxStop)
  );

  assign txPauseVec = txReq;
endmodule

// File: rtl/pfc_pause_gen_chk.sv
module pfc_pause_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] txPauseVec,
  input logic       txRefresh,
  input logic [7:0] txRelease,
  input logic       rxPfcValid,
  input logic       rxPauseValid,
  input logic       quantaTick,
  input logic [7:0] rxStop
);
  a_r7_refresh_on_new: assert property (@(posedge clk) disable iff (!rstN)
    ((txPauseVec & ~$past(txPauseVec)) != 8'd0) |-> txRefresh);

  a_r8_release_was_set: assert property (@(posedge clk) disable iff (!rstN)
    (txRelease != 8'd0) |-> ((txRelease & ~$past(txPauseVec)) == 8'd0));

  a_r8_release_now_clear: assert property (@(posedge clk) disable iff (!rstN)
    (txRelease != 8'd0) |-> ((txRelease & txPauseVec) == 8'd0));

  a_r9_stop_needs_rx: assert property (@(posedge clk) disable iff (!rstN)
    ((rxStop & ~$past(rxStop)) != 8'd0) |-> ($past(rxPfcValid) || $past(rxPauseValid)));

  a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(quantaTick) && !$past(rxPfcValid) && !$past(rxPauseValid)) |-> $stable(rxStop));
endmodule

bind pfc_pause_gen pfc_pause_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .txPauseVec(txPauseVec), .txRefresh(txRefresh),
  .txRelease(txRelease), .rxPfcValid(rxPfcValid), .rxPauseValid(rxPauseValid),
  .quantaTick(quantaTick), .rxStop(rxStop)
);

// File: tb/tb_pfc_pause_gen.sv
`timescale 1ns/1ps
module tb_pfc_pause_gen;
  localparam int NB = 8;
  localparam int BW = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [7:0] cfgMask = '0;
  logic cfgReject;
  logic [NB*BW-1:0] fillBytes = '0;
  logic rxPfcValid = 1'b0, rxPauseValid = 1'b0, quantaTick = 1'b0;
  logic [7:0] rxPrioVec = '0;
  logic [15:0] rxQuanta = '0;
  logic [7:0] txPauseVec, txRelease, rxStop;
  logic txRefresh;
  logic [15:0] txPauseTime;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pfc_pause_gen #(.NUM_BUF(NB), .BYTE_W(BW)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [7:0] m);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d; cfgMask = m;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic setFill(input int b, input int v);
    fillBytes[b*BW +: BW] = BW'(v);
  endtask

  function automatic logic [31:0] thr(input int xoff, input int xon, input bit lossy);
    return (32'(lossy) << 24) | (32'(xon) << 12) | 32'(xoff);
  endfunction

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int st, c, b, cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 txPauseVec", 32'(txPauseVec), 0);
    chk("R10 rxStop", 32'(rxStop), 0);
    chk("R10 txRefresh/release", {txRefresh, txRelease}, 0);
    chk("R10 txPauseTime", 32'(txPauseTime), 0);
    rstN = 1'b1;
    step();
    // R5: reset mask zero blocks everything
    setFill(0, 5000);
    step(); step();
    chk("R5 reset mask blocks", 32'(txPauseVec), 0);
    setFill(0, 0);
    wr(4'd8, thr(3, 2, 0), 8'h00);
    wr(4'd0, 32'h0000_00FF, 8'h00);
    step();
    // R1/R2 sweep through the hysteresis band
    st = 0;
    for (int i = 0; i < 80; i++) begin
      b = (i < 40) ? i * 17 : (79 - i) * 17;
      setFill(0, b);
      step();
      c = (b + 95) / 96;
      if (c > 3) st = 1;
      else if (c < 2) st = 0;
      chk($sformatf("R1 R2 sweep bytes=%0d", b), 32'(txPauseVec[0]), 32'(st));
    end
    // R1 rounding at the cell boundary
    setFill(0, 288); step();
    chk("R1 288 bytes is 3 cells, no pause", 32'(txPauseVec[0]), 0);
    setFill(0, 289); step();
    chk("R1 289 bytes is 4 cells, pause", 32'(txPauseVec[0]), 1);
    setFill(0, 0); step();
    // R2 equal thresholds
    wr(4'd8, thr(3, 3, 0), 8'h00);
    setFill(0, 288); step();
    chk("R2 equal at threshold holds clear", 32'(txPauseVec[0]), 0);
    setFill(0, 289); step();
    chk("R2 equal above sets", 32'(txPauseVec[0]), 1);
    setFill(0, 288); step();
    chk("R2 equal at threshold holds set", 32'(txPauseVec[0]), 1);
    setFill(0, 192); step();
    chk("R2 equal below clears", 32'(txPauseVec[0]), 0);
    wr(4'd8, thr(3, 2, 0), 8'h00);
    // R7 refresh spacing and pause time
    wr(4'd2, 32'h0004_1234, 8'h00);
    chk("R7 pause time", 32'(txPauseTime), 32'h1234);
    setFill(0, 1000); step();
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      if (txRefresh) cnt++;
      step();
    end
    chk("R7 refresh count over 12 cycles", 32'(cnt), 3);
    // R8 release
    setFill(0, 0); step();
    chk("R8 release strobe", {txPauseVec, txRelease}, 32'h0001);
    step();
    chk("R8 release one cycle", 32'(txRelease), 0);
    // R4 masked map update
    wr(4'd15, thr(3, 2, 0), 8'h00);
    wr(4'd1, 32'h7777_0077, 8'h0C);
    setFill(0, 1000); setFill(7, 1000); step();
    chk("R4 masked map", 32'(txPauseVec), 32'h8D);
    wr(4'd13, thr(3, 2, 0), 8'h00);
    setFill(5, 1000); step();
    chk("R4 identity entry", 32'(txPauseVec), 32'hAD);
    wr(4'd1, 32'h0090_0000, 8'h20);
    step();
    chk("R4 out-of-range index", 32'(txPauseVec), 32'h8D);
    // R3 lossy
    wr(4'd9, thr(0, 0, 1), 8'h00);
    setFill(1, 5000); step(); step();
    chk("R3 lossy never pauses", 32'(txPauseVec), 32'h8D);
    // R5 mask gating
    wr(4'd0, 32'h0000_0001, 8'h00);
    chk("R5 mask gating", 32'(txPauseVec), 32'h01);
    // R6 conflict refused
    cfgWe = 1'b1; cfgAddr = 4'd0; cfgData = 32'h0001_0001;
    #1;
    chk("R6 reject raised", 32'(cfgReject), 1);
    step(); cfgWe = 1'b0;
    chk("R6 policy unchanged", 32'(txPauseVec), 32'h01);
    wr(4'd0, 32'h0001_0000, 8'h00);
    chk("R6 global pauses all", 32'(txPauseVec), 32'hFF);
    for (int k = 0; k < NB; k++) setFill(k, 0);
    step();
    chk("R8 R6 global release", {txPauseVec, txRelease}, 32'h00FF);
    // R9 receive handling
    wr(4'd0, 32'h0000_0500, 8'h00);
    rxPfcValid = 1'b1; rxPrioVec = 8'h07; rxQuanta = 16'd3;
    step(); rxPfcValid = 1'b0;
    chk("R9 masked priority stop", 32'(rxStop), 32'h05);
    for (int k = 1; k <= 3; k++) begin
      quantaTick = 1'b1; step(); quantaTick = 1'b0;
      chk($sformatf("R9 after tick %0d", k), 32'(rxStop), (k < 3) ? 32'h05 : 32'h00);
    end
    rxPfcValid = 1'b1; rxPrioVec = 8'h02; rxQuanta = 16'd9;
    step(); rxPfcValid = 1'b0;
    chk("R9 unmasked priority ignored", 32'(rxStop), 0);
    wr(4'd0, 32'h0002_0500, 8'h00);
    rxPauseValid = 1'b1; rxQuanta = 16'd5;
    step(); rxPauseValid = 1'b0;
    chk("R9 global receive stops all", 32'(rxStop), 32'hFF);
    rxPfcValid = 1'b1; rxPrioVec = 8'h01; rxQuanta = 16'd0;
    step(); rxPfcValid = 1'b0;
    chk("R9 zero quanta releases", 32'(rxStop), 32'hFE);
    rxPauseValid = 1'b1;
    step(); rxPauseValid = 1'b0;
    chk("R9 global zero quanta", 32'(rxStop), 0);
    wr(4'd0, 32'h0000_0500, 8'h00);
    rxPauseValid = 1'b1; rxQuanta = 16'd5;
    step(); rxPauseValid = 1'b0;
    chk("R9 global receive disabled", 32'(rxStop), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule